// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host-facing data port and a local packet memory and moves data one transfer unit at a time under software control. Software programs a 16-bit start address and a 16-bit byte count through pairs of byte-wide registers. It then writes a command byte whose three-bit transfer field picks a read from memory, a write into memory, a send-packet transfer (which moves data in the read direction) or an abort. While a transfer is active, every host read strobe on the data port returns the memory contents at the current address. Every host write strobe stores the port data at that address.

Each access advances the current address by the transfer width (one byte, or two bytes when word mode is selected) and lowers the remaining count by the same amount. When the count runs out, the engine raises a sticky completion flag, returns to idle and ignores further port traffic. The completion flag is cleared by writing a one to its bit. Software can read the current address back at any time to follow progress. The command byte also carries two page-select bits and a start/stop pair. All registers other than the command byte are visible only while page 0 is selected.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the command register reads 0x21 (stop bit 0 set, transfer field 4, page 0), the status register reads 0x00, the current address reads 0x0000, and dp_rdata is 0.
- R2: Register offsets in page 0 are 1/2 start address low/high byte, 3/4 byte count low/high byte, 5/6 current address low/high byte (read), 7 status, 8 configuration. Issuing a read or write command loads the current address from the start address.
- R3: Command register (offset 0, every page) bits: 0 stop, 1 start, 5:3 transfer field, 7:6 page. Transfer field 1 = read, 3 = send packet (read direction), 2 = write, any value with bit 5 set = abort.
- R4: In a read or send transfer, dp_rdata shows the memory data at the current address (mem_addr), a dp_rd strobe asserts mem_rd, and the address then advances by the width.
- R5: In a write transfer, a dp_wr strobe asserts mem_we with mem_addr equal to the current address and mem_wdata equal to dp_wdata, and the address then advances by the width.
- R6: Configuration bit 0 selects word mode: 16-bit data and an address/count step of 2. In byte mode the step is 1 and only the low data byte is carried (upper byte 0).
- R7: When the count is used up, status bit 6 (value 0x40) sets, the engine goes idle, and later data-port strobes cause no memory access and no address change. The final current address equals start plus count (modulo 2^16).
- R8: Writing status with bit 6 = 1 clears the completion flag. Writing with bit 6 = 0 leaves it unchanged.
- R9: An abort command stops an active transfer at once, does not set the completion flag, and leaves the current address where it was.
- R10: Writes to offsets 1 to 8 take effect only while the page field is 0. With another page selected, those offsets read as 0.
- R11: A read or write command starts a transfer only if the start bit is 1 and the stop bit is 0 in the same written byte. A stop bit of 1 ends any active transfer without completion.
- R12: Starting a transfer with a byte count of 0 sets the completion flag at once and leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| dp_rd | input | 1 | Data port read strobe |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | 16 | Data port write data |
| dp_rdata | output | 16 | Data port read data |
| mem_addr | output | 16 | Packet memory address (current address) |
| mem_rd | output | 1 | Memory read access this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_wide | output | 1 | Word-mode indication for the memory |
| mem_rdata | input | 16 | Memory read data at mem_addr |

## Verification
The bench covers a transfer whose address runs through 0xFFFF and back to 0x0000. A design that fails to wrap at 16 bits would report the wrong final address. It also covers word-mode steps of two, which a design stepping by one would miss, and a strobe arriving after the count is used up. A design that keeps running there would produce a spurious memory write or read. Further tests apply an abort partway through a transfer, start a transfer with a zero count, and write commands with the start bit clear or the stop bit set. These expose an engine that flags completion on abort, hangs on a zero count, or starts without a proper start. Writing status with bit 6 clear, and writing start-address registers while page 1 is selected, catch loose write-one-to-clear logic and missing page gating.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int REG_AW = 4;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int DATA_W = 2 * BYTE_W;

    localparam logic [REG_AW-1:0] OFS_CMD    = 4'd0;
    localparam logic [REG_AW-1:0] OFS_SA_LO  = 4'd1;
    localparam logic [REG_AW-1:0] OFS_SA_HI  = 4'd2;
    localparam logic [REG_AW-1:0] OFS_BC_LO  = 4'd3;
    localparam logic [REG_AW-1:0] OFS_BC_HI  = 4'd4;
    localparam logic [REG_AW-1:0] OFS_CUR_LO = 4'd5;
    localparam logic [REG_AW-1:0] OFS_CUR_HI = 4'd6;
    localparam logic [REG_AW-1:0] OFS_STAT   = 4'd7;
    localparam logic [REG_AW-1:0] OFS_CFG    = 4'd8;

    localparam int CMD_STP   = 0;
    localparam int CMD_STA   = 1;
    localparam int CMD_ABORT = 5;
    localparam int STAT_DONE = 6;
    localparam int CFG_WORD  = 0;

    typedef enum logic [1:0] {XF_IDLE, XF_READ, XF_WRITE} xfer_mode_e;

    typedef struct packed {
        logic cmd;
        logic sa_lo;
        logic sa_hi;
        logic bc_lo;
        logic bc_hi;
        logic stat;
        logic cfg;
    } reg_wr_t;

    typedef struct packed {
        logic [1:0]        page;
        logic [2:0]        xfld;
        logic              sta;
        logic              stp;
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] cur;
        logic              word;
        logic              done;
        xfer_mode_e        mode;
    } eng_state_t;
endpackage

// File: rtl/rdma_reg_decode.sv
module rdma_reg_decode
    import rdma_pkg::*;
(
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        page,
    output reg_wr_t           wr
);
    always_comb begin
        wr = '0;
        if (reg_we) begin
            if (reg_addr == OFS_CMD) begin
                wr.cmd = 1'b1;
            end else if (page == 2'b00) begin
                case (reg_addr)
                    OFS_SA_LO: wr.sa_lo = 1'b1;
                    OFS_SA_HI: wr.sa_hi = 1'b1;
                    OFS_BC_LO: wr.bc_lo = 1'b1;
                    OFS_BC_HI: wr.bc_hi = 1'b1;
                    OFS_STAT:  wr.stat  = 1'b1;
                    OFS_CFG:   wr.cfg   = 1'b1;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rdma_read_mux.sv
module rdma_read_mux
    import rdma_pkg::*;
(
    input  logic [REG_AW-1:0] reg_addr,
    input  eng_state_t        st,
    output logic [BYTE_W-1:0] reg_rdata
);
    logic [BYTE_W-1:0] stat_byte;
    logic [BYTE_W-1:0] cfg_byte;

    always_comb begin
        stat_byte = '0;
        stat_byte[STAT_DONE] = st.done;
        cfg_byte = '0;
        cfg_byte[CFG_WORD] = st.word;
        reg_rdata = '0;
        if (reg_addr == OFS_CMD) begin
            reg_rdata = {st.page, st.xfld, 1'b0, st.sta, st.stp};
        end else if (st.page == 2'b00) begin
            case (reg_addr)
                OFS_CUR_LO: reg_rdata = st.cur[BYTE_W-1:0];
                OFS_CUR_HI: reg_rdata = st.cur[ADDR_W-1:BYTE_W];
                OFS_STAT:   reg_rdata = stat_byte;
                OFS_CFG:    reg_rdata = cfg_byte;
                default:    reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rdma_xfer_engine.sv
module rdma_xfer_engine
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_wr_t           wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              dp_rd,
    input  logic              dp_wr,
    output eng_state_t        st,
    output logic              acc_rd,
    output logic              acc_wr
);
    eng_state_t        d, q;
    logic [2:0]        cmd_fld;
    logic              kill, go;
    logic [ADDR_W-1:0] step;
    logic              unused_cmd_bit;

    assign unused_cmd_bit = wdata[2];
    assign cmd_fld = wdata[5:3];
    assign step    = q.word ? ADDR_W'(2) : ADDR_W'(1);
    assign kill    = wr.cmd && (wdata[CMD_STP] || wdata[CMD_ABORT]);
    assign go      = wr.cmd && !kill && wdata[CMD_STA] && (cmd_fld != 3'd0);
    assign acc_rd  = (q.mode == XF_READ)  && dp_rd && !wr.cmd;
    assign acc_wr  = (q.mode == XF_WRITE) && dp_wr && !wr.cmd;
    assign st      = q;

    always_comb begin
        d = q;
        if (wr.cmd) begin
            d.page = wdata[7:6];
            d.xfld = cmd_fld;
            d.sta  = wdata[CMD_STA];
            d.stp  = wdata[CMD_STP];
        end
        if (wr.sa_lo) d.sa[BYTE_W-1:0]       = wdata;
        if (wr.sa_hi) d.sa[ADDR_W-1:BYTE_W]  = wdata;
        if (wr.bc_lo) d.cnt[BYTE_W-1:0]      = wdata;
        if (wr.bc_hi) d.cnt[ADDR_W-1:BYTE_W] = wdata;
        if (wr.cfg)   d.word = wdata[CFG_WORD];
        if (wr.stat && wdata[STAT_DONE]) d.done = 1'b0;

        if (kill) begin
            d.mode = XF_IDLE;
        end else if (go) begin
            d.cur = q.sa;
            if (q.cnt == '0) begin
                d.done = 1'b1;
                d.mode = XF_IDLE;
            end else begin
                d.mode = (cmd_fld == 3'd2) ? XF_WRITE : XF_READ;
            end
        end else if (acc_rd || acc_wr) begin
            d.cur = q.cur + step;
            if (q.cnt <= step) begin
                d.cnt  = '0;
                d.done = 1'b1;
                d.mode = XF_IDLE;
            end else begin
                d.cnt = q.cnt - step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.xfld <= 3'd4;
            q.stp  <= 1'b1;
            q.mode <= XF_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic [DATA_W-1:0] dp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wide,
    input  logic [DATA_W-1:0] mem_rdata
);
    reg_wr_t    wr_sel;
    eng_state_t eng_st;
    logic       acc_rd, acc_wr;

    rdma_reg_decode u_dec (
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .page     (eng_st.page),
        .wr       (wr_sel)
    );

    rdma_xfer_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_sel),
        .wdata  (reg_wdata),
        .dp_rd  (dp_rd),
        .dp_wr  (dp_wr),
        .st     (eng_st),
        .acc_rd (acc_rd),
        .acc_wr (acc_wr)
    );

    rdma_read_mux u_rmux (
        .reg_addr  (reg_addr),
        .st        (eng_st),
        .reg_rdata (reg_rdata)
    );

    assign mem_addr  = eng_st.cur;
    assign mem_rd    = acc_rd;
    assign mem_we    = acc_wr;
    assign mem_wide  = eng_st.word;
    assign mem_wdata = eng_st.word ? dp_wdata : {{(DATA_W-BYTE_W){1'b0}}, dp_wdata[BYTE_W-1:0]};
    assign dp_rdata  = (eng_st.mode != XF_READ) ? '0 :
                       eng_st.word ? mem_rdata : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk
    import rdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              dp_rd,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input eng_state_t        st
);
    logic cmd_wr;
    assign cmd_wr = reg_we && (reg_addr == OFS_CMD);

    // R4: a read strobe during a read transfer advances the address by the width
    a_r4_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mode == XF_READ && dp_rd && !cmd_wr)
        |=> (st.cur == ADDR_W'($past(st.cur) + ($past(st.word) ? 2 : 1))));

    // R5: memory writes only happen in a write transfer, at the current address
    a_r5_we_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st.mode == XF_WRITE && mem_addr == st.cur));

    // R7: an idle engine keeps its address unless a command arrives
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st.mode == XF_IDLE && !cmd_wr) |=> $stable(st.cur));

    // R9: abort leaves the engine idle without flagging completion
    a_r9_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[CMD_ABORT] && !st.done) |=> (!st.done && st.mode == XF_IDLE));

    // R8: write-one-to-clear of the completion flag
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (st.done && st.mode == XF_IDLE && reg_we && reg_addr == OFS_STAT
         && st.page == 2'b00 && reg_wdata[STAT_DONE]) |=> !st.done);

    // R12: starting with a zero count completes at once
    a_r12_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[CMD_STA] && !reg_wdata[CMD_STP] && !reg_wdata[CMD_ABORT]
         && reg_wdata[5:3] != 3'd0 && st.cnt == '0) |=> (st.done && st.mode == XF_IDLE));

    // R3: a write command with a nonzero count enters the write transfer
    a_r3_write_go: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[CMD_STA] && !reg_wdata[CMD_STP] && reg_wdata[5:3] == 3'd2
         && st.cnt != '0) |=> (st.mode == XF_WRITE));
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dp_rd     (dp_rd),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .st        (eng_st)
);

// File: tb/rdma_port_engine_bench.sv
`timescale 1ns/1ps
module rdma_port_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0, dp_wr = 1'b0;
    logic [15:0] dp_wdata = '0, dp_rdata;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_we, mem_wide;

    int n_chk = 0, n_bad = 0;
    logic [15:0] s_rdata, s_addr, s_wdata;
    logic        s_mrd, s_mwe;

    always #10 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
    endfunction
    assign mem_rdata = memf(mem_addr);

    rdma_port_engine u_rdma_port_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_wide(mem_wide), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic cur_rd(output logic [15:0] v);
        logic [7:0] lo, hi;
        reg_rd(4'd5, lo);
        reg_rd(4'd6, hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input bit is_rd, input logic [15:0] wd);
        @(negedge clk);
        dp_rd = is_rd; dp_wr = !is_rd; dp_wdata = wd;
        #1;
        s_rdata = dp_rdata; s_addr = mem_addr; s_wdata = mem_wdata;
        s_mrd = mem_rd; s_mwe = mem_we;
        @(posedge clk); #1;
        dp_rd = 1'b0; dp_wr = 1'b0;
    endtask

    typedef struct packed {
        logic        word;
        logic [1:0]  kind;
        logic [15:0] sa;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 2'd0, 16'h1234, 16'd3},
        '{1'b1, 2'd1, 16'h0400, 16'd6},
        '{1'b0, 2'd2, 16'hFFFE, 16'd3},
        '{1'b1, 2'd0, 16'h0101, 16'd4},
        '{1'b0, 2'd1, 16'h00FF, 16'd2}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  rv;
        logic [15:0] cv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        reg_rd(4'd0, rv); check("R1 cmd", rv, 8'h21);
        reg_rd(4'd7, rv); check("R1 status", rv, 8'h00);
        cur_rd(cv);       check("R1 cur", cv, 16'h0000);
        check("R1 dp_rdata", dp_rdata, 16'h0000);

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        foreach (VECS[k]) begin
            vec_t v;
            logic [15:0] step, a, wd, exp;
            logic [7:0]  cmdv;
            int n;
            v = VECS[k];
            step = v.word ? 16'd2 : 16'd1;
            n = int'(v.cnt / step);
            cmdv = (v.kind == 2'd0) ? 8'h0A : (v.kind == 2'd1) ? 8'h12 : 8'h1A;
            reg_wr(4'd8, {7'b0, v.word});
            reg_wr(4'd1, v.sa[7:0]);
            reg_wr(4'd2, v.sa[15:8]);
            reg_wr(4'd3, v.cnt[7:0]);
            reg_wr(4'd4, v.cnt[15:8]);
            reg_wr(4'd0, cmdv);
            cur_rd(cv); check("R2 cur loaded", cv, v.sa);
            for (int i = 0; i < n; i++) begin
                a = v.sa + 16'(i) * step;
                if (v.kind == 2'd1) begin
                    wd = 16'hA55A ^ (16'(i) * 16'h0111);
                    pulse(1'b0, wd);
                    check("R5 mem_we", s_mwe, 1'b1);
                    check("R5 addr", s_addr, a);
                    check("R6 wdata", s_wdata, v.word ? wd : {8'h00, wd[7:0]});
                end else begin
                    pulse(1'b1, 16'h0);
                    exp = v.word ? memf(a) : {8'h00, memf(a)[7:0]};
                    check("R4 mem_rd", s_mrd, 1'b1);
                    check("R4 addr", s_addr, a);
                    check("R6 rdata", s_rdata, exp);
                end
            end
            reg_rd(4'd7, rv); check("R7 done", rv, 8'h40);
            cur_rd(cv); check("R7 final cur", cv, 16'(v.sa + v.cnt));
            pulse(v.kind != 2'd1, 16'hFFFF);
            check("R7 ignored rd", s_mrd, 1'b0);
            check("R7 ignored we", s_mwe, 1'b0);
            check("R7 ignored data", s_rdata, 16'h0000);
            cur_rd(cv); check("R7 cur stable", cv, 16'(v.sa + v.cnt));
            reg_wr(4'd7, 8'h40);
            reg_rd(4'd7, rv); check("R8 cleared", rv, 8'h00);
        end

        // R9: abort mid-transfer
        reg_wr(4'd8, 8'h00);
        reg_wr(4'd1, 8'h00); reg_wr(4'd2, 8'h20);
        reg_wr(4'd3, 8'd5);  reg_wr(4'd4, 8'h00);
        reg_wr(4'd0, 8'h0A);
        pulse(1'b1, 16'h0); pulse(1'b1, 16'h0);
        reg_wr(4'd0, 8'h22);
        reg_rd(4'd7, rv); check("R9 no done", rv, 8'h00);
        cur_rd(cv); check("R9 cur held", cv, 16'h2002);
        pulse(1'b1, 16'h0); check("R9 idle rd", s_mrd, 1'b0);

        // R10: page gating
        reg_wr(4'd1, 8'h00); reg_wr(4'd2, 8'h30);
        reg_wr(4'd3, 8'd1);  reg_wr(4'd4, 8'h00);
        reg_wr(4'd0, 8'h60);
        reg_wr(4'd1, 8'hAB);
        reg_rd(4'd6, rv); check("R10 page1 read", rv, 8'h00);
        reg_rd(4'd0, rv); check("R10 cmd any page", rv, 8'h60);
        reg_wr(4'd0, 8'h20);
        reg_wr(4'd0, 8'h0A);
        cur_rd(cv); check("R10 start unchanged", cv, 16'h3000);
        pulse(1'b1, 16'h0);
        reg_wr(4'd7, 8'h40);

        // R11: start gating
        reg_wr(4'd1, 8'h00); reg_wr(4'd2, 8'h40);
        reg_wr(4'd3, 8'd2);
        reg_wr(4'd0, 8'h08);
        pulse(1'b1, 16'h0); check("R11 no start bit", s_mrd, 1'b0);
        reg_wr(4'd0, 8'h0B);
        pulse(1'b1, 16'h0); check("R11 stop bit", s_mrd, 1'b0);
        cur_rd(cv); check("R11 cur untouched", cv, 16'h3001);
        reg_wr(4'd0, 8'h0A);
        pulse(1'b1, 16'h0); check("R11 proper start", s_mrd, 1'b1);
        reg_wr(4'd0, 8'h09);
        reg_rd(4'd7, rv); check("R11 stop no done", rv, 8'h00);
        pulse(1'b1, 16'h0); check("R11 stopped", s_mrd, 1'b0);

        // R12: zero count, then R8 partial writes
        reg_wr(4'd3, 8'h00); reg_wr(4'd4, 8'h00);
        reg_wr(4'd0, 8'h12);
        reg_rd(4'd7, rv); check("R12 done at once", rv, 8'h40);
        pulse(1'b0, 16'h1234); check("R12 idle", s_mwe, 1'b0);
        reg_wr(4'd7, 8'hBF);
        reg_rd(4'd7, rv); check("R8 zero bit keeps", rv, 8'h40);
        reg_wr(4'd7, 8'h40);
        reg_rd(4'd7, rv); check("R8 one bit clears", rv, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule